// File: doc/BRIEF.md
# Adaptive FSK Data Slicer

This block turns a stream of signed instantaneous-frequency samples into hard bit decisions. A frequency detector upstream presents one sample per strobe. The block follows the received signal as it moves between an upper and a lower frequency level. It registers a level change only when the frequency moves away from the extreme of the current level by more than half of a programmed expected deviation. Each change captures the extreme of the level just left, and the midpoint of the latest upper and lower levels goes into a moving-average window. The window average is the decision threshold, so a carrier offset between transmitter and receiver is removed from the slicing.

A 2-bit setting selects the averaging length. When the window holds at least that many entries, a settled flag is raised. The current threshold is also presented as a signed 8-bit frequency-offset estimate. A reset, or a rising edge of the receiver enable, restarts the learning. The intended training pattern is a 32-bit alternating sequence that starts with a 0.

Top module: `fsk_slicer`

## Requirements
- R1: After reset, and in the cycle after a rising edge of `rx_en`, `settled` is 0 and `freq_ofs` is 0. The level tracking and the averaging window are empty.
- R2: A strobe is ignored when `rx_en` is low, or when it falls in the cycle of an `rx_en` rising edge. In that case `bit_vld` stays 0 in the next cycle and `freq_ofs` does not change.
- R3: The first accepted sample opens a low level whose extreme is that sample. A low level switches to high when the sample minus the level minimum is strictly greater than floor(`exp_dev`/2). A high level switches to low when the level maximum minus the sample is strictly greater than floor(`exp_dev`/2). Otherwise the extreme is updated: the minimum for a low level, the maximum for a high level.
- R4: At a switch, the extreme of the level being left is stored as the new low value or high value. Once both values have been stored at least once, floor((high+low)/2) is pushed into the window. The newly opened level starts its extreme at the current sample.
- R5: `avg_sel` values 0, 1, 2 and 3 select windows of 2, 4, 8 and 16 entries. With the window full, the threshold is floor(sum of the newest N entries / N).
- R6: With fewer than N entries held, the threshold averages the newest 2^floor(log2(count)) entries. With no entries, the threshold is 0.
- R7: `settled` is 1 exactly when the number of entries held is at least N. It follows a change of `avg_sel` at once.
- R8: For each accepted sample, `bit_vld` is 1 one cycle later. `bit_out` then holds 1 if the sample was strictly greater than the threshold in force when it arrived, and 0 otherwise.
- R9: `freq_ofs` equals the current threshold, as a signed 8-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receiver enable; its rising edge restarts learning |
| smp_vld | input | 1 | Sample strobe |
| smp_freq | input | W (8) | Signed frequency sample |
| exp_dev | input | W (8) | Unsigned expected deviation |
| avg_sel | input | 2 | Averaging length select |
| bit_out | output | 1 | Sliced data bit |
| bit_vld | output | 1 | Sliced bit strobe |
| settled | output | 1 | Averaging window holds the selected length |
| freq_ofs | output | 8 | Signed frequency-offset estimate |

## Verification
The restart caused by an `rx_en` rising edge can coincide with a sample strobe. The bench provokes this on purpose at every segment boundary by holding `smp_vld` high through the enable-off cycle and through the rising-edge cycle. It then judges that no bit strobe follows, that the offset is unchanged or cleared, and that the next segment's model starts empty. Random segments of preamble and data are also used, with random deviation, carrier offset, noise and averaging length. These segments bring level switches and window saturation together, and every bit, flag and offset value is compared with an independent model of the rules above.

// File: rtl/fsk_slicer_pkg.sv
`timescale 1ns/1ps
package fsk_slicer_pkg;

  // floor of the mean of two levels
  function automatic int mid_of(input int a, input int b);
    return (a + b) >>> 1;
  endfunction

  // floor(log2(n)) for n >= 1, zero otherwise
  function automatic int floor_lg(input int n);
    int r;
    r = 0;
    for (int i = 1; i < 16; i++) begin
      if (n >= (1 << i)) r = i;
    end
    return r;
  endfunction

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/fsk_level_tracker.sv
`timescale 1ns/1ps
module fsk_level_tracker #(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                smp_en,
  input  logic signed [W-1:0] smp,
  input  logic        [W-1:0] half,
  output logic                push,
  output logic signed [W-1:0] push_val
);
  import fsk_slicer_pkg::*;

  logic                started, in_hi, have_hi, have_lo;
  logic signed [W-1:0] ext, hi_cap, lo_cap, nxt_hi, nxt_lo;
  logic signed [W:0]   rise_d, fall_d, half_x;
  logic                up, dn, trans;

  always_comb begin
    half_x   = $signed({1'b0, half});
    rise_d   = $signed({smp[W-1], smp}) - $signed({ext[W-1], ext});
    fall_d   = $signed({ext[W-1], ext}) - $signed({smp[W-1], smp});
    up       = started && !in_hi && (rise_d > half_x);
    dn       = started && in_hi && (fall_d > half_x);
    trans    = up || dn;
    nxt_hi   = dn ? ext : hi_cap;
    nxt_lo   = up ? ext : lo_cap;
    push     = smp_en && ((dn && have_lo) || (up && have_hi));
    push_val = W'(mid_of(int'(nxt_hi), int'(nxt_lo)));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      started <= 1'b0;
      in_hi   <= 1'b0;
      have_hi <= 1'b0;
      have_lo <= 1'b0;
      ext     <= '0;
      hi_cap  <= '0;
      lo_cap  <= '0;
    end else if (smp_en) begin
      if (!started) begin
        started <= 1'b1;
        in_hi   <= 1'b0;
        ext     <= smp;
      end else if (trans) begin
        in_hi   <= up;
        ext     <= smp;
        hi_cap  <= nxt_hi;
        lo_cap  <= nxt_lo;
        have_hi <= have_hi || dn;
        have_lo <= have_lo || up;
      end else if (in_hi && (smp > ext)) begin
        ext <= smp;
      end else if (!in_hi && (smp < ext)) begin
        ext <= smp;
      end
    end
  end

  // R3
  trk_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_en && trans && !clr) |=> (in_hi != $past(in_hi)));

  // R3
  trk_max_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_en && started && in_hi && !trans && !clr) |=> (ext >= $past(ext)));

endmodule

// File: rtl/fsk_avg_window.sv
`timescale 1ns/1ps
module fsk_avg_window #(
  parameter int W        = 8,
  parameter int DEPTH_LG = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                push,
  input  logic signed [W-1:0] push_val,
  input  logic [1:0]          sel,
  output logic signed [W-1:0] thr,
  output logic                settled
);
  import fsk_slicer_pkg::*;

  localparam int DEPTH = 1 << DEPTH_LG;
  localparam int SW    = W + DEPTH_LG;
  localparam int CW    = DEPTH_LG + 1;

  logic signed [W-1:0]  ent  [DEPTH];
  logic signed [SW-1:0] psum [DEPTH];
  logic [CW-1:0]        cnt;
  int                   lg_cap, lg_use;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (push && (int'(cnt) != DEPTH)) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) ent[0] <= push_val;
  end

  generate
    for (genvar g = 1; g < DEPTH; g++) begin : g_shift
      always_ff @(posedge clk) begin
        if (push) ent[g] <= ent[g-1];
      end
    end
  endgenerate

  assign psum[0] = SW'(ent[0]);
  generate
    for (genvar g = 1; g < DEPTH; g++) begin : g_sum
      assign psum[g] = psum[g-1] + SW'(ent[g]);
    end
  endgenerate

  always_comb begin
    lg_cap  = min_i(int'(sel) + 1, DEPTH_LG);
    lg_use  = min_i(lg_cap, floor_lg(int'(cnt)));
    settled = int'(cnt) >= (1 << lg_cap);
    if (cnt == '0) thr = '0;
    else thr = W'(psum[DEPTH_LG'((1 << lg_use) - 1)] >>> lg_use);
  end

  // R5
  win_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= DEPTH);

  // R1
  win_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  // R4
  win_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (int'(cnt) <= int'($past(cnt)) + 1));

endmodule

// File: rtl/fsk_slicer.sv
`timescale 1ns/1ps
module fsk_slicer #(
  parameter int W        = 8,
  parameter int DEPTH_LG = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_en,
  input  logic                smp_vld,
  input  logic signed [W-1:0] smp_freq,
  input  logic        [W-1:0] exp_dev,
  input  logic [1:0]          avg_sel,
  output logic                bit_out,
  output logic                bit_vld,
  output logic                settled,
  output logic signed [7:0]   freq_ofs
);
  logic                rx_q, clr, smp_en, push;
  logic signed [W-1:0] push_val, thr;
  logic        [W-1:0] half;

  assign clr    = rx_en && !rx_q;
  assign smp_en = smp_vld && rx_en && !clr;
  assign half   = exp_dev >> 1;

  fsk_level_tracker #(.W(W)) u_trk (
    .clk(clk), .rst(rst), .clr(clr), .smp_en(smp_en), .smp(smp_freq),
    .half(half), .push(push), .push_val(push_val)
  );

  fsk_avg_window #(.W(W), .DEPTH_LG(DEPTH_LG)) u_win (
    .clk(clk), .rst(rst), .clr(clr), .push(push), .push_val(push_val),
    .sel(avg_sel), .thr(thr), .settled(settled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q    <= 1'b1;
      bit_vld <= 1'b0;
      bit_out <= 1'b0;
    end else begin
      rx_q    <= rx_en;
      bit_vld <= smp_en;
      if (smp_en) bit_out <= (smp_freq > thr);
    end
  end

  assign freq_ofs = 8'(thr >>> (W - 8));

  // R8
  bit_vld_src_chk: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> $past(smp_vld && rx_en));

  // R1
  restart_settle_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !settled);

  // R9
  restart_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (freq_ofs == 8'sd0));

  // R2
  gated_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !rx_en) |=> !bit_vld);

endmodule

// File: tb/sim_fsk_slicer.sv
`timescale 1ns/1ps
module sim_fsk_slicer;
  logic              clk = 1'b0;
  logic              rst, rx_en, smp_vld;
  logic signed [7:0] smp_freq;
  logic [7:0]        exp_dev;
  logic [1:0]        avg_sel;
  logic              bit_out, bit_vld, settled;
  logic signed [7:0] freq_ofs;

  int n_chk = 0;
  int n_fail = 0;

  // independent model state
  int m_started, m_hi, m_ext, m_hc, m_lc, m_hh, m_hl, m_cnt;
  int win [16];

  always #2.5 clk = ~clk;

  fsk_slicer u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .smp_vld(smp_vld), .smp_freq(smp_freq),
    .exp_dev(exp_dev), .avg_sel(avg_sel), .bit_out(bit_out), .bit_vld(bit_vld),
    .settled(settled), .freq_ofs(freq_ofs)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int m_wlen_lg();
    return (int'(avg_sel) + 1 > 4) ? 4 : int'(avg_sel) + 1;
  endfunction

  function automatic int m_thr();
    int lg, k, sum;
    if (m_cnt == 0) return 0;
    k = 1;
    while (k * 2 <= m_cnt) k = k * 2;
    if (k > (1 << m_wlen_lg())) k = 1 << m_wlen_lg();
    lg = 0;
    while ((1 << lg) < k) lg++;
    sum = 0;
    for (int i = 0; i < k; i++) sum += win[i];
    return sum >>> lg;
  endfunction

  function automatic void m_clear();
    m_started = 0; m_hi = 0; m_ext = 0; m_hc = 0; m_lc = 0;
    m_hh = 0; m_hl = 0; m_cnt = 0;
  endfunction

  function automatic void m_push(input int v);
    for (int i = 15; i > 0; i--) win[i] = win[i-1];
    win[0] = v;
    if (m_cnt < 16) m_cnt++;
  endfunction

  function automatic void m_step(input int s);
    int half;
    half = int'(exp_dev) / 2;
    if (m_started == 0) begin
      m_started = 1; m_hi = 0; m_ext = s;
    end else if (m_hi == 0 && s - m_ext > half) begin
      m_lc = m_ext; m_hl = 1; m_hi = 1; m_ext = s;
      if (m_hh != 0) m_push((m_hc + m_lc) >>> 1);
    end else if (m_hi != 0 && m_ext - s > half) begin
      m_hc = m_ext; m_hh = 1; m_hi = 0; m_ext = s;
      if (m_hl != 0) m_push((m_hc + m_lc) >>> 1);
    end else if (m_hi != 0) begin
      if (s > m_ext) m_ext = s;
    end else begin
      if (s < m_ext) m_ext = s;
    end
  endfunction

  function automatic int clampi(input int v);
    return (v > 127) ? 127 : ((v < -128) ? -128 : v);
  endfunction

  // one accepted sample, called at a falling edge
  task automatic send(input int s);
    int exp_bit, th;
    th = m_thr();
    exp_bit = (s > th) ? 1 : 0;
    smp_vld = 1'b1;
    smp_freq = 8'(s);
    m_step(s);
    @(negedge clk);
    smp_vld = 1'b0;
    chk("R8", "bit_vld", int'(bit_vld), 1);
    chk("R8", "bit_out", int'(bit_out), exp_bit);
    chk("R7", "settled", int'(settled), (m_cnt >= (1 << m_wlen_lg())) ? 1 : 0);
    chk((m_cnt >= (1 << m_wlen_lg())) ? "R5" : "R6", "freq_ofs", int'(freq_ofs), m_thr());
  endtask

  // enable off with a strobe, then rising edge with a coincident strobe
  task automatic restart();
    int prev;
    prev = int'(freq_ofs);
    rx_en = 1'b0;
    smp_vld = 1'b1;
    smp_freq = 8'sd77;
    @(negedge clk);
    chk("R2", "bit_vld when disabled", int'(bit_vld), 0);
    chk("R2", "freq_ofs when disabled", int'(freq_ofs), prev);
    rx_en = 1'b1;
    smp_freq = -8'sd77;
    @(negedge clk);
    smp_vld = 1'b0;
    m_clear();
    chk("R2", "bit_vld on enable edge", int'(bit_vld), 0);
    chk("R1", "settled after restart", int'(settled), 0);
    chk("R1", "freq_ofs after restart", int'(freq_ofs), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed, dev, ofs, noise, lvl, b;
    seed = $urandom(1234);
    rst = 1'b1; rx_en = 1'b1; smp_vld = 1'b0; smp_freq = '0;
    exp_dev = 8'd20; avg_sel = 2'd0;
    for (int i = 0; i < 16; i++) win[i] = 0;
    m_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "settled after reset", int'(settled), 0);
    chk("R1", "freq_ofs after reset", int'(freq_ofs), 0);
    chk("R1", "bit_vld after reset", int'(bit_vld), 0);

    // R3 boundary: half of 20 is 10, a step of exactly 10 is no switch
    send(0);
    send(10);
    send(11);
    send(0);
    chk("R4", "first midpoint", int'(freq_ofs), 5);
    // odd deviation: half of 21 is still 10
    restart();
    exp_dev = 8'd21;
    send(-3);
    send(7);
    send(8);
    send(-3);
    chk("R3", "odd deviation switch", int'(freq_ofs), 2);
    // R4 negative rounding: floor((-3 + 0)/2) = -2
    restart();
    exp_dev = 8'd4;
    send(-3);
    send(0);
    send(-3);
    chk("R4", "negative midpoint floor", int'(freq_ofs), -2);
    // R7 select change takes effect at once
    send(0);
    send(-3);
    avg_sel = 2'd1;
    #1;
    chk("R7", "settled after select widening", int'(settled), 0);
    avg_sel = 2'd0;
    #1;
    chk("R7", "settled after select narrowing", int'(settled), 1);

    for (int seg = 0; seg < 10; seg++) begin
      restart();
      avg_sel = 2'($urandom % 4);
      dev = 20 + int'($urandom % 60);
      ofs = int'($urandom % 61) - 30;
      exp_dev = 8'(dev);
      for (int n = 0; n < 80; n++) begin
        b = (n < 32) ? (n % 2) : int'($urandom % 2);
        noise = int'($urandom % 7) - 3;
        lvl = ofs + ((b != 0) ? dev / 2 : -(dev / 2)) + noise;
        send(clampi(lvl));
        if (n == 40) avg_sel = 2'($urandom % 4);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule